// File: doc/BRIEF.md
# Byte-Lane Logic Execute Unit

This execute-stage unit computes the result of three logic operations of a 32-bit RISC pipeline, plus a plain copy of the first operand. Two of the operations combine the first register operand with a 16-bit immediate placed in the upper half of the word. One keeps the lower half of the operand and ANDs the upper half with the immediate. The other ORs the immediate into the upper half. The third operation builds a word lane by lane from two register operands under a 4-bit mask.

The decoder in front of the unit supplies both operands, the immediate, the mask and a 2-bit operation code. The unit works the same way whether the instruction named a separate destination or reused its first source as the destination. The computed value is captured in an output register on the clock edge where the input valid is high. It appears with a valid flag one cycle later and stays unchanged until the next accepted operation.

Top module: `blu_exec`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets `out_valid` to 0 and `out_result` to 0 after that edge.
- R2: Operation code 2'b00 gives `src_a & {imm, 16'hFFFF}`, so bits 15:0 of `src_a` pass through unchanged.
- R3: Operation code 2'b01 gives `src_a | {imm, 16'h0000}`, so bits 15:0 of `src_a` pass through unchanged.
- R4: Operation code 2'b10 merges lanes: result bits 8i+7:8i come from `src_b` when `lane_mask[i]` is 1 and from `src_a` when it is 0, for i = 0..3.
- R5: Operation code 2'b11 gives `src_a` unchanged.
- R6: `out_valid` after each rising edge equals `in_valid` sampled at that edge.
- R7: A rising edge with `in_valid` low leaves `out_result` unchanged.
- R8: Inputs the selected operation does not use have no effect: `src_b` and `lane_mask` for codes 00, 01 and 11, and `imm` for codes 10 and 11.
- R9: The result of an operation accepted at one rising edge is on `out_result` after that edge, so operations presented on consecutive cycles produce results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | Operation code (00 and-upper-ones, 01 or-upper, 10 lane merge, 11 copy) |
| src_a | input | 32 | First register operand (also the destination in two-operand forms) |
| src_b | input | 32 | Second register operand, used by the lane merge |
| imm | input | 16 | Immediate for the upper-half operations |
| lane_mask | input | 4 | Per-lane source select for the lane merge |
| out_valid | output | 1 | Result register holds a result from the previous cycle |
| out_result | output | 32 | Registered result |

## Verification
Every result passes through exactly one register, so a value driven before a rising edge is due on `out_result` and `out_valid` right after that edge. The bench drives inputs on the falling edge and samples on the next falling edge, half a cycle after the capturing edge. For streaming it checks each result one cycle after the previous one. In the idle case it checks that a cycle with `in_valid` low leaves the earlier value in place at the same sampling point.

// File: rtl/blu_pkg.sv
package blu_pkg;

  typedef enum logic [1:0] {
    BLU_AND_HI_ONES = 2'b00,
    BLU_OR_HI       = 2'b01,
    BLU_LANE_MERGE  = 2'b10,
    BLU_COPY_A      = 2'b11
  } blu_op_e;

endpackage

// File: rtl/blu_upper_logic.sv
module blu_upper_logic #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] and_ones_res,
  output logic [DATA_W-1:0] or_res
);
  localparam int LOW_W = DATA_W - IMM_W;

  // Upper field from the immediate, lower field filled with ones.
  function automatic logic [DATA_W-1:0] fill_ones(input logic [IMM_W-1:0] v);
    return {v, {LOW_W{1'b1}}};
  endfunction

  // Upper field from the immediate, lower field cleared.
  function automatic logic [DATA_W-1:0] fill_zeros(input logic [IMM_W-1:0] v);
    return {v, {LOW_W{1'b0}}};
  endfunction

  assign and_ones_res = opnd & fill_ones(imm);
  assign or_res       = opnd | fill_zeros(imm);

endmodule

// File: rtl/blu_lane_merge.sv
module blu_lane_merge #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [LANES-1:0]  sel_b,
  output logic [DATA_W-1:0] merged
);

  function automatic logic [LANE_W-1:0] pick_lane(input logic use_b,
                                                  input logic [LANE_W-1:0] la,
                                                  input logic [LANE_W-1:0] lb);
    return use_b ? lb : la;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      pick_lane(sel_b[g], opnd_a[g*LANE_W +: LANE_W], opnd_b[g*LANE_W +: LANE_W]);
  end

endmodule

// File: rtl/blu_result_reg.sv
module blu_result_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic              q_valid,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/blu_exec.sv
module blu_exec #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LANES-1:0]  lane_mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  import blu_pkg::*;

  logic [DATA_W-1:0] and_ones_res;
  logic [DATA_W-1:0] or_res;
  logic [DATA_W-1:0] merge_res;
  logic [DATA_W-1:0] next_result;   // mux output, observed by the checker
  blu_op_e           op;

  assign op = blu_op_e'(op_sel);

  blu_upper_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_upper (
    .opnd         (src_a),
    .imm          (imm),
    .and_ones_res (and_ones_res),
    .or_res       (or_res)
  );

  blu_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
    .opnd_a (src_a),
    .opnd_b (src_b),
    .sel_b  (lane_mask),
    .merged (merge_res)
  );

  always_comb begin
    unique case (op)
      BLU_AND_HI_ONES: next_result = and_ones_res;
      BLU_OR_HI:       next_result = or_res;
      BLU_LANE_MERGE:  next_result = merge_res;
      default:         next_result = src_a;
    endcase
  end

  blu_result_reg #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d       (next_result),
    .q_valid (out_valid),
    .q       (out_result)
  );

endmodule

// File: rtl/blu_exec_chk.sv
module blu_exec_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int LOW_W = DATA_W - IMM_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [IMM_W-1:0]  imm,
  input logic [LANES-1:0]  lane_mask,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [DATA_W-1:0] next_result
);

  logic rst_seen = 1'b0;
  always @(posedge clk) begin
    // R1: one edge after reset was sampled, the output register is cleared
    if (rst_seen) begin
      a_r1_reset_clear: assert (!out_valid && out_result == '0);
    end
    rst_seen <= rst;
  end

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));

  a_r9_capture_mux: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_result == $past(next_result));

  a_r2_low_kept_and: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00) |=>
      (out_result[LOW_W-1:0] == $past(src_a[LOW_W-1:0]) &&
       out_result[DATA_W-1:LOW_W] == ($past(src_a[DATA_W-1:LOW_W]) & $past(imm))));

  a_r3_low_kept_or: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01) |=>
      (out_result[LOW_W-1:0] == $past(src_a[LOW_W-1:0]) &&
       out_result[DATA_W-1:LOW_W] == ($past(src_a[DATA_W-1:LOW_W]) | $past(imm))));

  a_r5_copy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> out_result == $past(src_a));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    a_r4_lane_source: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b10) |=>
        out_result[i*LANE_W +: LANE_W] ==
          ($past(lane_mask[i]) ? $past(src_b[i*LANE_W +: LANE_W])
                               : $past(src_a[i*LANE_W +: LANE_W])));
  end

endmodule

bind blu_exec blu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_sel      (op_sel),
  .src_a       (src_a),
  .src_b       (src_b),
  .imm         (imm),
  .lane_mask   (lane_mask),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .next_result (next_result)
);

// File: tb/blu_exec_bench.sv
`timescale 1ns/1ps
module blu_exec_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic [15:0] imm;
  logic [3:0]  lane_mask;
  logic        out_valid;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  blu_exec u_blu_exec (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .src_a      (src_a),
    .src_b      (src_b),
    .imm        (imm),
    .lane_mask  (lane_mask),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] im;
    logic [3:0]  mk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 32'h12345678, 32'h00000000, 16'hF0F0, 4'h0, 32'h10305678, 8'd2}, // R2
    '{2'b00, 32'hFFFFFFFF, 32'h00000000, 16'h0000, 4'h0, 32'h0000FFFF, 8'd2}, // R2
    '{2'b01, 32'h00001234, 32'h00000000, 16'hABCD, 4'h0, 32'hABCD1234, 8'd3}, // R3
    '{2'b01, 32'h80000001, 32'h00000000, 16'h0F00, 4'h0, 32'h8F000001, 8'd3}, // R3
    '{2'b10, 32'h11223344, 32'hAABBCCDD, 16'h0000, 4'b0101, 32'h11BB33DD, 8'd4}, // R4
    '{2'b10, 32'h11223344, 32'hAABBCCDD, 16'h0000, 4'b0000, 32'h11223344, 8'd4}, // R4
    '{2'b10, 32'h11223344, 32'hAABBCCDD, 16'h0000, 4'b1111, 32'hAABBCCDD, 8'd4}, // R4
    '{2'b10, 32'h11223344, 32'hAABBCCDD, 16'h0000, 4'b1000, 32'hAA223344, 8'd4}, // R4
    '{2'b11, 32'hDEADBEEF, 32'h12345678, 16'h5555, 4'hF, 32'hDEADBEEF, 8'd5}, // R5
    '{2'b00, 32'h0000FFFF, 32'hFFFFFFFF, 16'hFFFF, 4'hF, 32'h0000FFFF, 8'd8}, // R8
    '{2'b10, 32'h00000000, 32'hFFFFFFFF, 16'hFFFF, 4'b0010, 32'h0000FF00, 8'd8}  // R8
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    n_checks++;
    if (got !== want) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic [3:0] mk);
    in_valid  = v;
    op_sel    = op;
    src_a     = a;
    src_b     = b;
    imm       = im;
    lane_mask = mk;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 2'b00, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 result", out_result, 32'd0);
    rst = 1'b0;

    // Table walk: each result due one edge after it was driven
    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VECS[k].op, VECS[k].a, VECS[k].b, VECS[k].im, VECS[k].mk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[k].req, k), out_result, VECS[k].exp);
      check("R6 valid high", {31'd0, out_valid}, 32'd1);
    end

    // R7 / R6: idle cycle with changed inputs keeps the old result
    drive(1'b0, 2'b11, 32'hCAFEF00D, 32'h0, 16'h0, 4'h0);
    @(negedge clk);
    check("R7 hold", out_result, 32'h0000FF00);
    check("R6 valid low", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R7 hold second", out_result, 32'h0000FF00);

    // R9: back-to-back operations land on consecutive cycles
    drive(1'b1, 2'b11, 32'h01020304, 32'h0, 16'h0, 4'h0);
    @(negedge clk);
    check("R9 first", out_result, 32'h01020304);
    drive(1'b1, 2'b01, 32'h000000AA, 32'h0, 16'h5A00, 4'h0);
    @(negedge clk);
    check("R9 second", out_result, 32'h5A0000AA);
    drive(1'b1, 2'b00, 32'hFFFF0001, 32'h0, 16'h00FF, 4'h0);
    @(negedge clk);
    check("R9 third", out_result, 32'h00FF0001);

    // R1: reset in mid-stream overrides a valid operation
    rst = 1'b1;
    drive(1'b1, 2'b11, 32'h77777777, 32'h0, 16'h0, 4'h0);
    @(negedge clk);
    check("R1 mid reset result", out_result, 32'd0);
    check("R1 mid reset valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    drive(1'b0, 2'b00, '0, '0, '0, '0);
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule